// File: doc/BRIEF.md
# Vector Source Operand Prefix Unit

This block rewrites the two four-lane source operands of a vector instruction before they reach the arithmetic pipeline. Each lane holds one IEEE-754 single-precision word. For every lane, a 20-bit prefix word picks either one of the original input lanes or a value from a built-in table of eight constants. It then optionally forces the sign positive and optionally flips it. Only the sign bit is manipulated; no floating-point arithmetic is done.

Three prefix registers live inside the block. Operand A is shaped by the first register and operand B by the second. The third (destination) register is held here for a downstream saturation stage and is exposed on a port. A prefix-set command loads one of them. Each vector operation consumes all three, so they fall back to their neutral values afterwards. Results appear one clock after the operation is presented, with a flag that marks operands left untouched by a neutral prefix.

Top module: `vpfx_unit`

## Requirements
- R1: After reset the A and B prefix registers hold 0xE4, the destination prefix holds 0, `out_valid_o` is low and both result buses are zero.
- R2: A set command (`set_valid_i`) writes `set_word_i[19:0]` into the register chosen by `set_word_i[25:24]`: 0 selects A, 1 selects B, 2 selects destination. Selector 3 writes no register.
- R3: For an active lane i, the selected source is the input lane given by prefix bits [2i+1:2i]. Every lane reads the unmodified input lanes, so lanes may repeat or reorder sources freely.
- R4: With the constant flag (bit 12+i) clear, the abs flag (bit 8+i) clears bit 31 of the selected word. After that, the negate flag (bit 16+i) inverts bit 31.
- R5: With the constant flag set, lane i takes the table entry at index {abs flag, lane index bits}. The entries for indices 0 to 7 are 0x00000000, 0x3F800000, 0x40000000, 0x3F000000, 0x40400000, 0x3EAAAAAB, 0x3E800000 and 0x3E2AAAAB. The negate flag still inverts bit 31.
- R6: A non-constant lane whose source index is not below the active lane count reads input lane 0 instead.
- R7: `op_size_i` encodes the active lane count minus one. Lanes at or above that count are passed through unchanged.
- R8: `ident_a_o`/`ident_b_o` are high exactly when the prefix used for that operand equals 0xE4, and the result then equals the input.
- R9: A vector operation (`op_valid_i`) returns the A and B prefixes to 0xE4 and the destination prefix to 0 on the following clock.
- R10: When a set command and an operation arrive in the same cycle, the operation uses the prefixes held before that cycle. The targeted register then keeps the new payload, and the other registers are cleared.
- R11: Results, identity flags and `out_valid_o` are registered one clock after `op_valid_i`. `out_valid_o` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid_i | input | 1 | Prefix-set command strobe |
| set_word_i | input | 32 | Prefix-set command: payload [19:0], selector [25:24] |
| op_valid_i | input | 1 | Vector operation strobe; consumes the prefixes |
| op_size_i | input | 2 | Active lane count minus one |
| src_a_i | input | 128 | Operand A lanes, lane i at bits [32i+31:32i] |
| src_b_i | input | 128 | Operand B lanes, same layout |
| out_valid_o | output | 1 | Results valid |
| res_a_o | output | 128 | Transformed operand A |
| res_b_o | output | 128 | Transformed operand B |
| ident_a_o | output | 1 | Operand A prefix was neutral |
| ident_b_o | output | 1 | Operand B prefix was neutral |
| pfx_d_o | output | 20 | Current destination prefix |

## Verification
The hardest situation to reach is a prefix and an operation interacting across cycles. This covers a set command that lands in the same cycle as a consuming operation, and a selector-3 command that must leave state alone. The prefix is invisible except through a later operation, so the stimulus follows such commands with a second operation and checks what it used. Random prefixes are paired with random sizes so that out-of-range swizzle indices and inactive lanes occur often. Directed sequences sweep all eight constants with and without negation.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;

    localparam int LANES   = 4;
    localparam int ELEM_W  = 32;
    localparam int VEC_W   = LANES * ELEM_W;
    localparam int PFX_W   = 20;
    localparam int SIZE_W  = $clog2(LANES);
    localparam int SEL_LSB = 24;

    localparam logic [PFX_W-1:0] PFX_NEUTRAL_SRC = 20'h000E4;
    localparam logic [PFX_W-1:0] PFX_NEUTRAL_DST = 20'h00000;

    // field offsets inside a source prefix
    localparam int ABS_OFS   = 8;
    localparam int CONST_OFS = 12;
    localparam int NEG_OFS   = 16;

    typedef enum logic [1:0] {
        PSEL_A   = 2'd0,
        PSEL_B   = 2'd1,
        PSEL_DST = 2'd2,
        PSEL_BAD = 2'd3
    } pfx_sel_e;

    typedef struct packed {
        logic [PFX_W-1:0] a;
        logic [PFX_W-1:0] b;
        logic [PFX_W-1:0] dst;
    } pfx_bank_t;

    typedef struct packed {
        logic             valid;
        logic             ident_a;
        logic             ident_b;
        logic [VEC_W-1:0] res_a;
        logic [VEC_W-1:0] res_b;
    } out_stage_t;

    function automatic logic [ELEM_W-1:0] const_word(input logic [2:0] k);
        logic [ELEM_W-1:0] w;
        case (k)
            3'd0:    w = 32'h0000_0000;
            3'd1:    w = 32'h3F80_0000;
            3'd2:    w = 32'h4000_0000;
            3'd3:    w = 32'h3F00_0000;
            3'd4:    w = 32'h4040_0000;
            3'd5:    w = 32'h3EAA_AAAB;
            3'd6:    w = 32'h3E80_0000;
            default: w = 32'h3E2A_AAAB;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/vpfx_regs.sv
module vpfx_regs
    import vpfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [1:0]       set_sel,
    input  logic [PFX_W-1:0] set_data,
    input  logic             consume,
    output logic [PFX_W-1:0] pfx_a,
    output logic [PFX_W-1:0] pfx_b,
    output logic [PFX_W-1:0] pfx_dst
);

    pfx_bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (consume) begin
            bank_d.a   = PFX_NEUTRAL_SRC;
            bank_d.b   = PFX_NEUTRAL_SRC;
            bank_d.dst = PFX_NEUTRAL_DST;
        end
        if (set_valid) begin
            case (pfx_sel_e'(set_sel))
                PSEL_A:   bank_d.a   = set_data;
                PSEL_B:   bank_d.b   = set_data;
                PSEL_DST: bank_d.dst = set_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.a   <= PFX_NEUTRAL_SRC;
            bank_q.b   <= PFX_NEUTRAL_SRC;
            bank_q.dst <= PFX_NEUTRAL_DST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pfx_a   = bank_q.a;
    assign pfx_b   = bank_q.b;
    assign pfx_dst = bank_q.dst;

endmodule

// File: rtl/vpfx_lane.sv
module vpfx_lane
    import vpfx_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [1:0]        swz,
    input  logic              abs_f,
    input  logic              const_f,
    input  logic              neg_f,
    input  logic [SIZE_W-1:0] size,
    input  logic [VEC_W-1:0]  src,
    output logic [ELEM_W-1:0] lane_out
);

    localparam logic [SIZE_W-1:0] MY_IDX = LANE_IDX[SIZE_W-1:0];
    localparam int                SGN    = ELEM_W - 1;

    logic              active;
    logic [1:0]        pick;
    logic [ELEM_W-1:0] picked;
    logic [ELEM_W-1:0] shaped;

    always_comb begin
        active = (MY_IDX <= size);
        pick   = (swz <= size) ? swz : 2'd0;
        picked = src[pick*ELEM_W +: ELEM_W];

        if (const_f) begin
            shaped = const_word({abs_f, swz});
        end else begin
            shaped = picked;
            if (abs_f)
                shaped[SGN] = 1'b0;
        end
        if (neg_f)
            shaped[SGN] = ~shaped[SGN];

        lane_out = active ? shaped : src[LANE_IDX*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/vpfx_xform.sv
module vpfx_xform
    import vpfx_pkg::*;
(
    input  logic [PFX_W-1:0]  prefix,
    input  logic [SIZE_W-1:0] size,
    input  logic [VEC_W-1:0]  src,
    output logic [VEC_W-1:0]  dst,
    output logic              neutral
);

    assign neutral = (prefix == PFX_NEUTRAL_SRC);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vpfx_lane #(.LANE_IDX(g)) u_lane (
            .swz      (prefix[2*g +: 2]),
            .abs_f    (prefix[ABS_OFS + g]),
            .const_f  (prefix[CONST_OFS + g]),
            .neg_f    (prefix[NEG_OFS + g]),
            .size     (size),
            .src      (src),
            .lane_out (dst[g*ELEM_W +: ELEM_W])
        );
    end

endmodule

// File: rtl/vpfx_unit.sv
module vpfx_unit
    import vpfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid_i,
    input  logic [31:0]          set_word_i,
    input  logic                 op_valid_i,
    input  logic [SIZE_W-1:0]    op_size_i,
    input  logic [VEC_W-1:0]     src_a_i,
    input  logic [VEC_W-1:0]     src_b_i,
    output logic                 out_valid_o,
    output logic [VEC_W-1:0]     res_a_o,
    output logic [VEC_W-1:0]     res_b_o,
    output logic                 ident_a_o,
    output logic                 ident_b_o,
    output logic [PFX_W-1:0]     pfx_d_o
);

    logic [PFX_W-1:0] pfx_a, pfx_b;
    logic [VEC_W-1:0] xa, xb;
    logic             na, nb;
    logic             unused_cmd_bits;

    assign unused_cmd_bits = ^{set_word_i[31:SEL_LSB+2], set_word_i[SEL_LSB-1:PFX_W]};

    vpfx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (set_valid_i),
        .set_sel   (set_word_i[SEL_LSB +: 2]),
        .set_data  (set_word_i[PFX_W-1:0]),
        .consume   (op_valid_i),
        .pfx_a     (pfx_a),
        .pfx_b     (pfx_b),
        .pfx_dst   (pfx_d_o)
    );

    vpfx_xform u_xa (
        .prefix  (pfx_a),
        .size    (op_size_i),
        .src     (src_a_i),
        .dst     (xa),
        .neutral (na)
    );

    vpfx_xform u_xb (
        .prefix  (pfx_b),
        .size    (op_size_i),
        .src     (src_b_i),
        .dst     (xb),
        .neutral (nb)
    );

    out_stage_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = op_valid_i;
        if (op_valid_i) begin
            out_d.res_a   = xa;
            out_d.res_b   = xb;
            out_d.ident_a = na;
            out_d.ident_b = nb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid_o = out_q.valid;
    assign res_a_o     = out_q.res_a;
    assign res_b_o     = out_q.res_b;
    assign ident_a_o   = out_q.ident_a;
    assign ident_b_o   = out_q.ident_b;

endmodule

// File: rtl/vpfx_chk.sv
module vpfx_chk
    import vpfx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             set_valid_i,
    input logic [31:0]      set_word_i,
    input logic             op_valid_i,
    input logic [VEC_W-1:0] src_a_i,
    input logic             out_valid_o,
    input logic [VEC_W-1:0] res_a_o,
    input logic             ident_a_o,
    input logic [PFX_W-1:0] pfx_d_o
);

    // R11
    op_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> out_valid_o);

    // R11
    no_op_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !out_valid_o);

    // R9
    consume_clears_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !set_valid_i) |=> (pfx_d_o == PFX_NEUTRAL_DST));

    // R2
    dst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid_i && set_word_i[SEL_LSB +: 2] == 2'd2) |=> (pfx_d_o == $past(set_word_i[PFX_W-1:0])));

    // R2
    bad_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid_i && set_word_i[SEL_LSB +: 2] == 2'd3 && !op_valid_i) |=> $stable(pfx_d_o));

    // R8
    neutral_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i ##1 ident_a_o) |-> (res_a_o == $past(src_a_i)));

endmodule

bind vpfx_unit vpfx_chk u_vpfx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_valid_i (set_valid_i),
    .set_word_i  (set_word_i),
    .op_valid_i  (op_valid_i),
    .src_a_i     (src_a_i),
    .out_valid_o (out_valid_o),
    .res_a_o     (res_a_o),
    .ident_a_o   (ident_a_o),
    .pfx_d_o     (pfx_d_o)
);

// File: tb/tb_vpfx_unit.sv
`timescale 1ns/1ps
module tb_vpfx_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         set_valid_i;
    logic [31:0]  set_word_i;
    logic         op_valid_i;
    logic [1:0]   op_size_i;
    logic [127:0] src_a_i, src_b_i;
    logic         out_valid_o;
    logic [127:0] res_a_o, res_b_o;
    logic         ident_a_o, ident_b_o;
    logic [19:0]  pfx_d_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [19:0] m_a, m_b, m_d;

    always #10 clk = ~clk;

    vpfx_unit dut (
        .clk(clk), .rst_n(rst_n), .set_valid_i(set_valid_i), .set_word_i(set_word_i),
        .op_valid_i(op_valid_i), .op_size_i(op_size_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .out_valid_o(out_valid_o), .res_a_o(res_a_o), .res_b_o(res_b_o),
        .ident_a_o(ident_a_o), .ident_b_o(ident_b_o), .pfx_d_o(pfx_d_o)
    );

    function automatic logic [31:0] tbl(input int k);
        case (k)
            0: return 32'h00000000;
            1: return 32'h3F800000;
            2: return 32'h40000000;
            3: return 32'h3F000000;
            4: return 32'h40400000;
            5: return 32'h3EAAAAAB;
            6: return 32'h3E800000;
            default: return 32'h3E2AAAAB;
        endcase
    endfunction

    function automatic logic [127:0] ref_vec(input logic [19:0] p, input logic [1:0] sz,
                                             input logic [127:0] s);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) begin
            int sel;
            logic [31:0] w;
            sel = int'(p[2*i +: 2]);
            if (i > int'(sz)) begin
                w = s[32*i +: 32];
            end else begin
                if (p[12+i])
                    w = tbl(sel + (p[8+i] ? 4 : 0));
                else begin
                    if (sel > int'(sz)) sel = 0;
                    w = s[32*sel +: 32];
                    if (p[8+i]) w[31] = 1'b0;
                end
                if (p[16+i]) w[31] = ~w[31];
            end
            r[32*i +: 32] = w;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus with full checking
    task automatic step(input bit sv, input logic [31:0] sw, input bit ov,
                        input logic [1:0] sz, input logic [127:0] a, input logic [127:0] b,
                        input string tag);
        logic [127:0] ea, eb;
        bit ia, ib;
        @(negedge clk);
        set_valid_i = sv; set_word_i = sw; op_valid_i = ov;
        op_size_i = sz; src_a_i = a; src_b_i = b;
        ea = ref_vec(m_a, sz, a);
        eb = ref_vec(m_b, sz, b);
        ia = (m_a == 20'hE4);
        ib = (m_b == 20'hE4);
        if (ov) begin m_a = 20'hE4; m_b = 20'hE4; m_d = 20'h0; end
        if (sv) begin
            case (sw[25:24])
                2'd0: m_a = sw[19:0];
                2'd1: m_b = sw[19:0];
                2'd2: m_d = sw[19:0];
                default: ;
            endcase
        end
        @(negedge clk);
        set_valid_i = 1'b0; op_valid_i = 1'b0;
        chk(out_valid_o == ov, "R11 out_valid", 128'(out_valid_o), 128'(ov));
        chk(pfx_d_o == m_d, "R2/R9 dst prefix", 128'(pfx_d_o), 128'(m_d));
        if (ov) begin
            chk(res_a_o == ea, {tag, " operand A"}, res_a_o, ea);
            chk(res_b_o == eb, {tag, " operand B"}, res_b_o, eb);
            chk(ident_a_o == ia, "R8 ident A", 128'(ident_a_o), 128'(ia));
            chk(ident_b_o == ib, "R8 ident B", 128'(ident_b_o), 128'(ib));
        end
    endtask

    function automatic logic [127:0] rvec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    localparam logic [127:0] VA = {32'hC1200000, 32'h40A00000, 32'hBF800000, 32'h3F800000};
    localparam logic [127:0] VB = {32'h44444444, 32'hB3333333, 32'h22222222, 32'h91111111};

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; set_valid_i = 0; set_word_i = 0; op_valid_i = 0;
        op_size_i = 0; src_a_i = 0; src_b_i = 0;
        m_a = 20'hE4; m_b = 20'hE4; m_d = 20'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(out_valid_o == 0, "R1 out_valid", 128'(out_valid_o), 0);
        chk(res_a_o == 0 && res_b_o == 0, "R1 results", res_a_o, 0);
        chk(pfx_d_o == 0, "R1 dst prefix", 128'(pfx_d_o), 0);
        rst_n = 1'b1;
        // R1 R8 neutral prefixes after reset pass input through
        step(0, 0, 1, 2'd3, VA, VB, "R1 R8 neutral");
        // R3 reversal and broadcast, R4 abs/negate
        step(1, 32'h0000001B, 0, 0, 0, 0, "R2 load A");
        step(1, 32'h01000055, 0, 0, 0, 0, "R2 load B");
        step(0, 0, 1, 2'd3, VA, VB, "R3 swizzle");
        step(1, 32'h000A0FE4, 0, 0, 0, 0, "R2 load A");
        step(1, 32'h010F0500, 0, 0, 0, 0, "R2 load B");
        step(0, 0, 1, 2'd3, VA, VB, "R4 abs negate");
        // R5 all constants
        step(1, 32'h0000F0E4, 0, 0, 0, 0, "R2 load A");
        step(1, 32'h010AFFE4, 0, 0, 0, 0, "R2 load B");
        step(0, 0, 1, 2'd3, VA, VB, "R5 constants");
        // R6 out of range, R7 inactive lanes
        step(1, 32'h000000FF, 0, 0, 0, 0, "R2 load A");
        step(1, 32'h0100001B, 0, 0, 0, 0, "R2 load B");
        step(0, 0, 1, 2'd1, VA, VB, "R6 R7 size two");
        step(1, 32'h0000001B, 0, 0, 0, 0, "R2 load A");
        step(0, 0, 1, 2'd0, VA, VB, "R6 R7 size one");
        // R2 selector 3 writes nothing; R9 consume reset
        step(1, 32'h02012345, 0, 0, 0, 0, "R2 load dst");
        step(1, 32'h030000FF, 0, 0, 0, 0, "R2 bad selector");
        step(0, 0, 1, 2'd3, VA, VB, "R2 bad selector no effect");
        step(0, 0, 1, 2'd3, VA, VB, "R9 cleared after op");
        // R10 set and op in same cycle
        step(1, 32'h0000001B, 0, 0, 0, 0, "R2 load A");
        step(1, 32'h01000000, 1, 2'd3, VA, VB, "R10 same cycle");
        step(0, 0, 1, 2'd3, VA, VB, "R10 new payload kept");
        // random traffic
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            w = $urandom;
            if ((k % 7) == 0) w[19:0] = 20'hE4;
            step(($urandom % 3) != 0, w, ($urandom % 2) == 0, 2'($urandom),
                 rvec(), rvec(), "R3 R4 R5 R6 random");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule